// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block sits in the master-clock domain of an audio converter. It counts the master clocks in each period of the frame (left/right) clock and decides which of four supported ratios is in use: 256, 384, 512 or 768 master clocks per sample. When the interface is a clock slave, the ratio is found automatically. When it is clock master, the ratio comes from a select input instead. The block derives the divider that the oversampling datapath needs from that ratio.

While the detected ratio is trusted, samples from the datapath pass through a capture register. When a frame period misses every tolerance window, the block flags the ratio as invalid and the register keeps the last good sample. The valid flag also drops for any ratio that cannot run at the reduced 64fs oversampling.

Top module: `audio_ratio_detect`

## Requirements
- R1: After reset, `ratio_valid` is 0 and `smp_out` is 0. Both stay so in slave mode until a ratio has been committed.
- R2: In slave mode, a steady frame period of 256, 384, 512 or 768 master clocks yields `ratio_code` 0, 1, 2 or 3 respectively, with `ratio_valid` = 1.
- R3: A period counts as a match when it lies within 32 master clocks of a supported ratio, bounds included. For example, 224 and 288 match 256, and 800 matches 768. Periods of 223, 289 and 801 match nothing.
- R4: A ratio is committed only after two consecutive measured periods match the same ratio. A single period that matches a different ratio changes neither `ratio_code` nor `ratio_valid`.
- R5: In slave mode, a measured period that matches no ratio clears `ratio_valid` when that measurement completes.
- R6: When `ratio_valid` is 1 and `smp_stb` is 1 at a clock edge, `smp_out` takes `smp_in` at that edge. Otherwise `smp_out` keeps its value.
- R7: With `master_en` = 1, `ratio_code` equals `ratio_sel` (same encoding as R2). `ratio_valid` is 1 without any frame clock activity, unless R10 applies.
- R8: `osr_div` equals the ratio divided by 128 when `half_osr` = 0, giving 2, 3, 4 or 6. It equals the ratio divided by 64 when `half_osr` = 1, giving 4, 6, 8 or 12.
- R9: The period counter saturates at 1023. A period of 1280 clocks is therefore a miss and does not wrap onto the 256 window.
- R10: With `half_osr` = 1, ratio codes 2 and 3 (512 and 768) force `ratio_valid` to 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, synchronous release assumed |
| frame_clk | input | 1 | Frame (left/right) clock, synchronous to mclk with phase jitter |
| master_en | input | 1 | 1: ratio taken from `ratio_sel`; 0: ratio detected |
| ratio_sel | input | 2 | Ratio select used in master mode (0=256, 1=384, 2=512, 3=768) |
| half_osr | input | 1 | 1: 64fs oversampling; 0: 128fs |
| smp_in | input | SMP_W (24) | Sample from the datapath |
| smp_stb | input | 1 | Qualifies `smp_in` |
| ratio_code | output | 2 | Ratio in use (encoding as `ratio_sel`) |
| ratio_valid | output | 1 | Ratio trusted and supported at the chosen oversampling |
| smp_out | output | SMP_W (24) | Captured sample, frozen while `ratio_valid` is 0 |
| osr_div | output | DIV_W (4) | Master clocks per oversampled tick |

## Verification
The assertions assume that `frame_clk` changes away from the master-clock edge and that `rst_n` is held for several cycles. They also assume the mode and select inputs change only between measurements, so that a single commit sees one consistent configuration. The stimulus drives every input on the falling edge of `mclk`. It builds frames with exact high and low lengths, and it changes configuration only while the frame clock is idle or between whole frames. Successive frame runs can stretch one measured period by eight clocks. The scenarios are sized so that this stretch stays inside a tolerance window, or is overridden by later exact periods, before any check.

// File: rtl/arcd_pkg.sv
`timescale 1ns/1ps
package arcd_pkg;
   localparam int NUM_RATIOS = 4;

   typedef enum logic [1:0] {
      RATIO_256 = 2'd0,
      RATIO_384 = 2'd1,
      RATIO_512 = 2'd2,
      RATIO_768 = 2'd3
   } ratio_e;

   function automatic int unsigned ratio_mclks(input logic [1:0] code);
      case (code)
         2'd0:    return 256;
         2'd1:    return 384;
         2'd2:    return 512;
         default: return 768;
      endcase
   endfunction
endpackage

// File: rtl/lrck_sync_edge.sv
`timescale 1ns/1ps
module lrck_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] pipe;
   logic              last;

   initial begin
      if (STAGES < 1) $error("lrck_sync_edge: STAGES must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= async_in;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-2:0], async_in};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= 1'b0;
      else        last <= pipe[STAGES-1];
   end

   assign rise = pipe[STAGES-1] & ~last;

   // a detected edge never repeats on the next cycle
   p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/lrck_period_meter.sv
`timescale 1ns/1ps
module lrck_period_meter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic [CNT_W-1:0] len,
   output logic             len_stb
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt;
   logic             armed;

   initial begin
      if (CNT_W < 2) $error("lrck_period_meter: CNT_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         armed   <= 1'b0;
         len     <= '0;
         len_stb <= 1'b0;
      end else begin
         len_stb <= 1'b0;
         if (rise) begin
            cnt   <= CNT_W'(1);
            armed <= 1'b1;
            if (armed) begin
               len     <= cnt;
               len_stb <= 1'b1;
            end
         end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // counter sticks at its ceiling until the next edge (R9)
   p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && !rise) |=> cnt == CNT_MAX);
   // a completed measurement is never zero clocks long
   p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      len_stb |-> len != '0);
endmodule

// File: rtl/ratio_match_lock.sv
`timescale 1ns/1ps
module ratio_match_lock
   import arcd_pkg::*;
#(
   parameter int          CNT_W = 10,
   parameter int unsigned TOL   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] len,
   input  logic             len_stb,
   output logic [1:0]       code,
   output logic             locked
);
   logic [NUM_RATIOS-1:0] hit;
   logic [1:0]            hit_code;
   logic                  hit_any;
   logic [31:0]           len_w;
   logic [1:0]            cand_code;
   logic                  cand_ok;

   initial begin
      if (TOL >= 64) $error("ratio_match_lock: windows would overlap");
      if ((1 << CNT_W) - 1 < 768 + TOL) $error("ratio_match_lock: CNT_W too narrow");
   end

   assign len_w = 32'(len);

   generate
      for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
         localparam int unsigned CENTER = ratio_mclks(2'(g));
         assign hit[g] = (len_w >= CENTER - TOL) && (len_w <= CENTER + TOL);
      end
   endgenerate

   always_comb begin
      hit_code = 2'd0;
      for (int i = 0; i < NUM_RATIOS; i++) begin
         if (hit[i]) hit_code = 2'(i);
      end
   end

   assign hit_any = |hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code      <= 2'd0;
         locked    <= 1'b0;
         cand_code <= 2'd0;
         cand_ok   <= 1'b0;
      end else if (len_stb) begin
         if (hit_any) begin
            if (cand_ok && cand_code == hit_code) begin
               code   <= hit_code;
               locked <= 1'b1;
            end
            cand_code <= hit_code;
            cand_ok   <= 1'b1;
         end else begin
            cand_ok <= 1'b0;
            locked  <= 1'b0;
         end
      end
   end

   // windows are disjoint (R3)
   p_windows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
   // lock is only gained on a completed measurement (R4)
   p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(len_stb));
   // committed code only moves with a measurement (R4)
   p_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !len_stb |=> $stable(code));
endmodule

// File: rtl/sample_freeze.sv
`timescale 1ns/1ps
module sample_freeze #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         stb,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   initial begin
      if (W < 1) $error("sample_freeze: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dout <= '0;
      else if (en && stb)  dout <= din;
   end

   // output frozen whenever no qualified capture happens (R6)
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && stb) |=> $stable(dout));
endmodule

// File: rtl/audio_ratio_detect.sv
`timescale 1ns/1ps
module audio_ratio_detect
   import arcd_pkg::*;
#(
   parameter int          SMP_W       = 24,
   parameter int          CNT_W       = 10,
   parameter int unsigned TOL         = 32,
   parameter int          SYNC_STAGES = 2,
   parameter int          DIV_W       = 4
) (
   input  logic             mclk,
   input  logic             rst_n,
   input  logic             frame_clk,
   input  logic             master_en,
   input  logic [1:0]       ratio_sel,
   input  logic             half_osr,
   input  logic [SMP_W-1:0] smp_in,
   input  logic             smp_stb,
   output logic [1:0]       ratio_code,
   output logic             ratio_valid,
   output logic [SMP_W-1:0] smp_out,
   output logic [DIV_W-1:0] osr_div
);
   localparam int OSR_SHIFT = 7;

   logic             fr_rise;
   logic [CNT_W-1:0] per_len;
   logic             per_stb;
   logic [1:0]       det_code;
   logic             det_locked;
   logic             rate_ok;
   logic [DIV_W-1:0] base_div;

   initial begin
      if (DIV_W < 4) $error("audio_ratio_detect: DIV_W must hold 12");
   end

   lrck_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(mclk), .rst_n(rst_n), .async_in(frame_clk), .rise(fr_rise));

   lrck_period_meter #(.CNT_W(CNT_W)) u_meter (
      .clk(mclk), .rst_n(rst_n), .rise(fr_rise), .len(per_len), .len_stb(per_stb));

   ratio_match_lock #(.CNT_W(CNT_W), .TOL(TOL)) u_lock (
      .clk(mclk), .rst_n(rst_n), .len(per_len), .len_stb(per_stb),
      .code(det_code), .locked(det_locked));

   assign ratio_code  = master_en ? ratio_sel : det_code;
   assign rate_ok     = !(half_osr && ratio_code[1]);
   assign ratio_valid = (master_en | det_locked) & rate_ok;

   assign base_div = DIV_W'(ratio_mclks(ratio_code) >> OSR_SHIFT);
   assign osr_div  = half_osr ? (base_div << 1) : base_div;

   sample_freeze #(.W(SMP_W)) u_hold (
      .clk(mclk), .rst_n(rst_n), .en(ratio_valid), .stb(smp_stb),
      .din(smp_in), .dout(smp_out));

   // divider always in the legal range (R8)
   p_div_r8: assert property (@(posedge mclk) disable iff (!rst_n)
      osr_div >= DIV_W'(2) && osr_div <= DIV_W'(12));
   // no high ratio is trusted at 64fs (R10)
   p_hires_r10: assert property (@(posedge mclk) disable iff (!rst_n)
      (ratio_valid && half_osr) |-> !ratio_code[1]);
endmodule

// File: tb/audio_ratio_detect_tb_top.sv
`timescale 1ns/1ps
module audio_ratio_detect_tb_top;
   logic        mclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_clk = 1'b0;
   logic        master_en = 1'b0;
   logic [1:0]  ratio_sel = 2'd0;
   logic        half_osr = 1'b0;
   logic [23:0] smp_in = '0;
   logic        smp_stb = 1'b0;
   logic [1:0]  ratio_code;
   logic        ratio_valid;
   logic [23:0] smp_out;
   logic [3:0]  osr_div;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4ns mclk = ~mclk;

   audio_ratio_detect dut_i (
      .mclk(mclk), .rst_n(rst_n), .frame_clk(frame_clk), .master_en(master_en),
      .ratio_sel(ratio_sel), .half_osr(half_osr), .smp_in(smp_in), .smp_stb(smp_stb),
      .ratio_code(ratio_code), .ratio_valid(ratio_valid), .smp_out(smp_out),
      .osr_div(osr_div));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge mclk);
   endtask

   task automatic do_reset(input bit mst);
      @(negedge mclk);
      rst_n = 1'b0; frame_clk = 1'b0; smp_stb = 1'b0; master_en = mst;
      cycles(4);
      rst_n = 1'b1;
      cycles(2);
   endtask

   task automatic run(input int p, input int n);
      for (int i = 0; i < n; i++) begin
         frame_clk = 1'b1; cycles(p / 2);
         frame_clk = 1'b0; cycles(p - p / 2);
      end
   endtask

   task automatic probe;
      frame_clk = 1'b1;
      cycles(8);
   endtask

   task automatic push(input logic [23:0] v);
      smp_in = v; smp_stb = 1'b1;
      cycles(1);
      smp_stb = 1'b0;
   endtask

   task automatic t_reset;
      half_osr = 1'b0;
      do_reset(1'b0);
      chk("R1 valid after reset", ratio_valid, 0);
      chk("R1 sample after reset", smp_out, 0);
      push(24'hABCDEF);
      chk("R1 no capture before lock", smp_out, 0);
   endtask

   task automatic t_classify(input int p, input int code);
      do_reset(1'b0);
      run(p, 3); probe;
      chk($sformatf("R2 code for %0d", p), ratio_code, code);
      chk($sformatf("R2 valid for %0d", p), ratio_valid, 1);
   endtask

   task automatic t_tol(input int good, input int bad, input int lockp);
      do_reset(1'b0);
      run(good, 3); probe;
      chk($sformatf("R3 period %0d matches", good), ratio_valid, 1);
      do_reset(1'b0);
      run(lockp, 3); probe;
      run(bad, 3); probe;
      chk($sformatf("R3 period %0d misses", bad), ratio_valid, 0);
   endtask

   task automatic t_hyst;
      do_reset(1'b0);
      run(256, 3); probe;
      run(384, 1); probe;
      chk("R4 single other period keeps code", ratio_code, 0);
      chk("R4 single other period keeps valid", ratio_valid, 1);
      run(256, 2); probe;
      run(512, 1); probe;
      chk("R4 one 512 period not enough", ratio_code, 0);
      run(512, 1); probe;
      chk("R4 two 512 periods commit", ratio_code, 2);
      chk("R4 valid after recommit", ratio_valid, 1);
   endtask

   task automatic t_miss_hold;
      do_reset(1'b0);
      run(384, 3); probe;
      push(24'h123456);
      chk("R6 capture while valid", smp_out, 24'h123456);
      push(24'h0F0F0F);
      chk("R6 second capture", smp_out, 24'h0F0F0F);
      run(320, 2); probe;
      chk("R5 miss clears valid", ratio_valid, 0);
      push(24'h777777);
      chk("R6 frozen while invalid", smp_out, 24'h0F0F0F);
   endtask

   task automatic t_sat;
      do_reset(1'b0);
      run(256, 3); probe;
      run(1280, 2); probe;
      chk("R9 long period is a miss", ratio_valid, 0);
   endtask

   task automatic t_master;
      do_reset(1'b1);
      ratio_sel = 2'd3; half_osr = 1'b0; cycles(1);
      chk("R7 master code", ratio_code, 3);
      chk("R7 master valid", ratio_valid, 1);
      chk("R8 768 at 128fs", osr_div, 6);
      half_osr = 1'b1; cycles(1);
      chk("R10 768 at 64fs invalid", ratio_valid, 0);
      ratio_sel = 2'd1; cycles(1);
      chk("R7 master code 384", ratio_code, 1);
      chk("R10 384 at 64fs valid", ratio_valid, 1);
      chk("R8 384 at 64fs", osr_div, 6);
      ratio_sel = 2'd0; half_osr = 1'b0; cycles(1);
      chk("R8 256 at 128fs", osr_div, 2);
      half_osr = 1'b1; cycles(1);
      chk("R8 256 at 64fs", osr_div, 4);
      master_en = 1'b0; half_osr = 1'b0;
   endtask

   task automatic t_slave_div;
      do_reset(1'b0);
      run(768, 3); probe;
      chk("R8 slave 768 divider", osr_div, 6);
      half_osr = 1'b1; cycles(1);
      chk("R10 slave 768 at 64fs", ratio_valid, 0);
      chk("R8 slave 768 at 64fs divider", osr_div, 12);
      half_osr = 1'b0;
      do_reset(1'b0);
      run(512, 3); probe;
      chk("R8 slave 512 divider", osr_div, 4);
      half_osr = 1'b1; cycles(1);
      chk("R10 slave 512 at 64fs", ratio_valid, 0);
      half_osr = 1'b0;
   endtask

   initial begin
      t_reset;
      t_classify(256, 0);
      t_classify(384, 1);
      t_classify(512, 2);
      t_classify(768, 3);
      t_tol(288, 289, 256);
      t_tol(224, 223, 256);
      t_tol(800, 801, 768);
      t_hyst;
      t_miss_hold;
      t_sat;
      t_master;
      t_slave_div;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge mclk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule